// File: doc/BRIEF.md
# Flash Status Register Unit

This block keeps the eight-bit status word of a flash-style memory controller. An abstracted program/erase engine reports what it is doing through single-cycle event pulses: an operation starting, an operation finishing, a program failure, an erase failure, an erase being suspended or resumed, and sleep being entered or left. A command decoder can pulse a clear request that wipes the two failure flags. The engine may raise those flags but can never lower them, so failures from a series of operations pile up until the host clears them.

The host reads the word through a synchronous read port qualified by two active-low strobes, output enable and chip enable, both sampled on the system clock. A read cycle begins on the first clock at which both strobes are low. At that edge the unit freezes a copy of the status. The copy stays on the read port until the strobes are released and asserted again, so a host that polls for completion must end each read and start a new one. The port is word-wide or byte-wide under a mode input. An error-lock flag goes back to the command decoder whenever a failure flag is set, so the decoder can limit the commands it accepts.

Status bit map (bit positions are part of the behaviour): bit 7 ready (1 = idle, 0 = busy), bit 6 erase suspended, bit 5 erase failed, bit 4 program failed, bit 2 asleep; bits 3, 1 and 0 are always 0.

Top module: `flash_status_unit`

## Requirements
- R1: After reset the status word is 80h, `err_lock` is 0 and `rd_data` is all zero.
- R2: A start pulse clears bit 7 and a done pulse sets bit 7; when both arrive in the same cycle, bit 7 ends at 1.
- R3: A program-fail pulse sets bit 4 and an erase-fail pulse sets bit 5; neither is cleared by later start, done, suspend, resume or sleep events.
- R4: A clear pulse returns bits 4 and 5 to 0; a failure pulse in the same cycle as a clear leaves its bit at 1.
- R5: A suspend pulse is accepted only while bit 7 is 0 and bit 6 is 0, and then sets bits 7 and 6 together; a resume pulse is accepted only while bit 6 is 1, and then clears bits 6 and 7; otherwise each is ignored.
- R6: A sleep-enter pulse sets bit 2 unless bit 6 is 1, in which case it is ignored; a sleep-exit pulse clears bit 2.
- R7: Bits 3, 1 and 0 of the status always read as 0.
- R8: On the clock edge where both read strobes are first seen low together, the status as it stood before that edge is captured, and from the next cycle `rd_data` shows that copy unchanged for as long as both strobes stay low, whatever events arrive meanwhile.
- R9: In any cycle following a clock edge at which either read strobe was high, `rd_data` is all zero.
- R10: With `word_mode` = 1 every bit of `rd_data` above bit 7 is 0; with `word_mode` = 0 each upper byte lane of `rd_data` repeats the captured status byte.
- R11: `err_lock` is 1 exactly when bit 4 or bit 5 of the current status is 1, changing in the cycle after the event that changes those bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_start | input | 1 | Engine began a program or erase |
| evt_done | input | 1 | Engine finished its operation |
| evt_prog_fail | input | 1 | Page program failed |
| evt_erase_fail | input | 1 | Erase failed to verify |
| evt_suspend | input | 1 | Erase suspend requested |
| evt_resume | input | 1 | Erase resume requested |
| evt_sleep_enter | input | 1 | Device entering sleep |
| evt_sleep_exit | input | 1 | Device waking from sleep |
| clr_status | input | 1 | Clear the failure flags |
| rd_oe_n | input | 1 | Read output enable, active low |
| rd_ce_n | input | 1 | Chip enable, active low |
| word_mode | input | 1 | 1 = word-wide read, 0 = byte-wide read |
| rd_data | output | DATA_W | Captured status as presented to the host |
| err_lock | output | 1 | A failure flag is set |

## Verification
The bench builds the unit with the default 16-bit read port, which gives exactly one upper byte lane, so both the forced-zero word format and the mirrored byte format are exercised against the same captured value. With that width, reads taken in the same cycle as an event show the pre-edge capture, and holding the strobes low across later events shows the frozen copy. Event collisions (start with done, failure with clear, suspend or sleep in the wrong state) are driven one at a time and read back through the port.

// File: rtl/fsu_pkg.sv
// Shared constants for the flash status register unit.
// Assumes an eight-bit status word; bit positions are fixed by the host view.
package fsu_pkg;
    localparam int unsigned ST_W      = 8;
    localparam int unsigned BIT_READY = 7;
    localparam int unsigned BIT_SUSP  = 6;
    localparam int unsigned BIT_EFAIL = 5;
    localparam int unsigned BIT_PFAIL = 4;
    localparam int unsigned BIT_SLEEP = 2;
    localparam logic [ST_W-1:0] ST_RESET = 8'h80;
endpackage

// File: rtl/fsu_strobe_detect.sv
// Read strobe qualifier: the read is active when every active-low strobe is
// low; the start of a read is the first active sample after an inactive one.
// Assumes the strobes are already synchronous to clk.
module fsu_strobe_detect #(
    parameter int unsigned N_STB = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_STB-1:0] stb_n,
    output logic             rd_active,
    output logic             rd_begin,
    output logic             rd_was
);
    logic prev_q;

    assign rd_active = ~|stb_n;
    assign rd_begin  = rd_active & ~prev_q;
    assign rd_was    = prev_q;

    // Remember the previous activity sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= rd_active;
    end
endmodule

// File: rtl/fsu_status_core.sv
// Status word state: ready, suspend, failure and sleep bits updated from
// engine event pulses and the clear command. Reserved bits are tied low.
// Assumes events are single-cycle pulses; conflicts resolve in a fixed order.
module fsu_status_core
    import fsu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            evt_start,
    input  logic            evt_done,
    input  logic            evt_prog_fail,
    input  logic            evt_erase_fail,
    input  logic            evt_suspend,
    input  logic            evt_resume,
    input  logic            evt_sleep_enter,
    input  logic            evt_sleep_exit,
    input  logic            clr_status,
    output logic [ST_W-1:0] status,
    output logic            fail_any
);
    logic ready_q, susp_q, efail_q, pfail_q, sleep_q;
    logic ready_d, susp_d, efail_d, pfail_d, sleep_d;
    logic sus_ok, res_ok;

    // Acceptance of suspend and resume depends on the current state.
    always_comb begin
        sus_ok = evt_suspend & ~ready_q & ~susp_q;
        res_ok = evt_resume & susp_q;
    end

    // Next-state for ready and suspend, later lines take priority.
    always_comb begin
        ready_d = ready_q;
        susp_d  = susp_q;
        if (evt_start) ready_d = 1'b0;
        if (evt_done)  ready_d = 1'b1;
        if (sus_ok) begin
            ready_d = 1'b1;
            susp_d  = 1'b1;
        end
        if (res_ok) begin
            ready_d = 1'b0;
            susp_d  = 1'b0;
        end
    end

    // Sticky failure flags: a set in the same cycle beats the clear.
    always_comb begin
        pfail_d = (pfail_q & ~clr_status) | evt_prog_fail;
        efail_d = (efail_q & ~clr_status) | evt_erase_fail;
    end

    // Sleep flag: entry is refused while an erase is suspended.
    always_comb begin
        sleep_d = sleep_q;
        if (evt_sleep_enter && !susp_q) sleep_d = 1'b1;
        if (evt_sleep_exit)             sleep_d = 1'b0;
    end

    // State registers with the documented reset value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= ST_RESET[BIT_READY];
            susp_q  <= ST_RESET[BIT_SUSP];
            efail_q <= ST_RESET[BIT_EFAIL];
            pfail_q <= ST_RESET[BIT_PFAIL];
            sleep_q <= ST_RESET[BIT_SLEEP];
        end else begin
            ready_q <= ready_d;
            susp_q  <= susp_d;
            efail_q <= efail_d;
            pfail_q <= pfail_d;
            sleep_q <= sleep_d;
        end
    end

    // Assemble the word; unassigned positions stay 0.
    always_comb begin
        status            = '0;
        status[BIT_READY] = ready_q;
        status[BIT_SUSP]  = susp_q;
        status[BIT_EFAIL] = efail_q;
        status[BIT_PFAIL] = pfail_q;
        status[BIT_SLEEP] = sleep_q;
    end

    assign fail_any = efail_q | pfail_q;
endmodule

// File: rtl/fsu_snapshot.sv
// Read snapshot and port formatting: captures the status at the start of a
// read and presents it until the read ends, in word or byte format.
// Assumes DATA_W is a multiple of 8 and at least 8.
module fsu_snapshot
    import fsu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ST_W-1:0]   status,
    input  logic              rd_active,
    input  logic              rd_begin,
    input  logic              word_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_on
);
    localparam int unsigned LANES = DATA_W / ST_W;

    logic [ST_W-1:0] snap_q;
    logic            on_q;

    // Freeze the status at the first active sample of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)        snap_q <= '0;
        else if (rd_begin) snap_q <= status;
    end

    // Track whether a read was active at the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= rd_active;
    end

    assign rd_on = on_q;

    // Lane 0 always carries the status byte.
    assign rd_data[ST_W-1:0] = on_q ? snap_q : '0;

    // Upper lanes: zero in word mode, mirrored byte in byte mode.
    for (genvar g = 1; g < LANES; g++) begin : g_lane
        assign rd_data[g*ST_W +: ST_W] = (on_q && !word_mode) ? snap_q : '0;
    end
endmodule

// File: rtl/flash_status_unit.sv
// Top of the flash status register unit: ties the strobe qualifier, the
// status state and the read snapshot together and exports the error lock.
// Assumes synchronous strobes and single-cycle event pulses.
module flash_status_unit
    import fsu_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_start,
    input  logic              evt_done,
    input  logic              evt_prog_fail,
    input  logic              evt_erase_fail,
    input  logic              evt_suspend,
    input  logic              evt_resume,
    input  logic              evt_sleep_enter,
    input  logic              evt_sleep_exit,
    input  logic              clr_status,
    input  logic              rd_oe_n,
    input  logic              rd_ce_n,
    input  logic              word_mode,
    output logic [DATA_W-1:0] rd_data,
    output logic              err_lock
);
    logic [ST_W-1:0] status_w;
    logic            active_w, begin_w, was_w, on_w, fail_w;

    fsu_strobe_detect #(.N_STB(2)) i_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_n     ({rd_oe_n, rd_ce_n}),
        .rd_active (active_w),
        .rd_begin  (begin_w),
        .rd_was    (was_w)
    );

    fsu_status_core i_core (
        .clk             (clk),
        .rst_n           (rst_n),
        .evt_start       (evt_start),
        .evt_done        (evt_done),
        .evt_prog_fail   (evt_prog_fail),
        .evt_erase_fail  (evt_erase_fail),
        .evt_suspend     (evt_suspend),
        .evt_resume      (evt_resume),
        .evt_sleep_enter (evt_sleep_enter),
        .evt_sleep_exit  (evt_sleep_exit),
        .clr_status      (clr_status),
        .status          (status_w),
        .fail_any        (fail_w)
    );

    fsu_snapshot #(.DATA_W(DATA_W)) i_snap (
        .clk       (clk),
        .rst_n     (rst_n),
        .status    (status_w),
        .rd_active (active_w),
        .rd_begin  (begin_w),
        .word_mode (word_mode),
        .rd_data   (rd_data),
        .rd_on     (on_w)
    );

    assign err_lock = fail_w;
endmodule

// File: rtl/fsu_checker.sv
// Property checker for flash_status_unit, attached by bind below.
module fsu_checker #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_prog_fail,
    input logic              evt_suspend,
    input logic              evt_resume,
    input logic              evt_sleep_enter,
    input logic              clr_status,
    input logic              rd_oe_n,
    input logic              rd_ce_n,
    input logic              word_mode,
    input logic [DATA_W-1:0] rd_data,
    input logic              err_lock,
    input logic [7:0]        status,
    input logic              rd_on
);
    p_reset_value_r1: assert property (@(posedge clk)
        !rst_n |=> (status == 8'h80));

    p_pfail_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status[4] && !clr_status) |=> status[4]);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !evt_prog_fail) |=> !status[4]);

    p_suspend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_suspend && !status[7] && !status[6]) |=> (status[7] && status[6]));

    p_resume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_resume && status[6]) |=> (!status[6] && !status[7]));

    p_sleep_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sleep_enter && status[6] && !status[2]) |=> !status[2]);

    p_reserved_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[3] == 1'b0) && (rd_data[1:0] == 2'b00));

    p_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_oe_n && !rd_ce_n && rd_on) |=> ($stable(rd_data) || !$stable(word_mode)));

    p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_on |-> (rd_data == '0));

    p_lock_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !evt_prog_fail && !status[5]) |=> !err_lock);

    if (DATA_W > 8) begin : g_upper
        p_word_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_on && word_mode) |-> (rd_data[DATA_W-1:8] == '0));
    end
endmodule

bind flash_status_unit fsu_checker #(.DATA_W(DATA_W)) i_fsu_checker (
    .clk             (clk),
    .rst_n           (rst_n),
    .evt_prog_fail   (evt_prog_fail),
    .evt_suspend     (evt_suspend),
    .evt_resume      (evt_resume),
    .evt_sleep_enter (evt_sleep_enter),
    .clr_status      (clr_status),
    .rd_oe_n         (rd_oe_n),
    .rd_ce_n         (rd_ce_n),
    .word_mode       (word_mode),
    .rd_data         (rd_data),
    .err_lock        (err_lock),
    .status          (status_w),
    .rd_on           (on_w)
);

// File: tb/test_flash_status_unit.sv
module test_flash_status_unit;
    localparam int unsigned DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic evt_start = 0, evt_done = 0, evt_prog_fail = 0, evt_erase_fail = 0;
    logic evt_suspend = 0, evt_resume = 0, evt_sleep_enter = 0, evt_sleep_exit = 0;
    logic clr_status = 0;
    logic rd_oe_n = 1, rd_ce_n = 1, word_mode = 1;
    logic [DATA_W-1:0] rd_data;
    logic err_lock;

    int n_checks = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    flash_status_unit #(.DATA_W(DATA_W)) i_flash_status_unit (
        .clk(clk), .rst_n(rst_n),
        .evt_start(evt_start), .evt_done(evt_done),
        .evt_prog_fail(evt_prog_fail), .evt_erase_fail(evt_erase_fail),
        .evt_suspend(evt_suspend), .evt_resume(evt_resume),
        .evt_sleep_enter(evt_sleep_enter), .evt_sleep_exit(evt_sleep_exit),
        .clr_status(clr_status), .rd_oe_n(rd_oe_n), .rd_ce_n(rd_ce_n),
        .word_mode(word_mode), .rd_data(rd_data), .err_lock(err_lock)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One clock: edge, then settle to the falling edge for sampling.
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_events();
        evt_start = 0; evt_done = 0; evt_prog_fail = 0; evt_erase_fail = 0;
        evt_suspend = 0; evt_resume = 0; evt_sleep_enter = 0; evt_sleep_exit = 0;
        clr_status = 0;
    endtask

    // Complete read cycle: both strobes low for one edge, then release.
    task automatic read_status(output logic [DATA_W-1:0] v);
        rd_oe_n = 0; rd_ce_n = 0;
        tick();
        v = rd_data;
        rd_oe_n = 1; rd_ce_n = 1;
        tick();
    endtask

    task automatic expect_status(input string req, input logic [7:0] exp);
        logic [DATA_W-1:0] v;
        read_status(v);
        check(req, v, {8'h00, exp});
        check("R7", {24'h0, v[7:0] & 8'h0B}, 32'h0);
    endtask

    task automatic t_reset();
        check("R1 rd_data idle", rd_data, 0);
        check("R1 err_lock", err_lock, 0);
        expect_status("R1 reset word", 8'h80);
    endtask

    task automatic t_busy_done();
        evt_start = 1; tick(); clear_events();
        expect_status("R2 busy", 8'h00);
        evt_done = 1; tick(); clear_events();
        expect_status("R2 done", 8'h80);
        evt_start = 1; evt_done = 1; tick(); clear_events();
        expect_status("R2 start+done", 8'h80);
    endtask

    task automatic t_fail();
        evt_start = 1; tick(); clear_events();
        evt_prog_fail = 1; evt_done = 1; tick(); clear_events();
        check("R11 lock after pfail", err_lock, 1);
        expect_status("R3 pfail", 8'h90);
        evt_start = 1; tick(); clear_events();
        expect_status("R3 pfail held busy", 8'h10);
        evt_erase_fail = 1; evt_done = 1; tick(); clear_events();
        expect_status("R3 both fails", 8'hB0);
    endtask

    task automatic t_clear();
        clr_status = 1; tick(); clear_events();
        check("R11 lock cleared", err_lock, 0);
        expect_status("R4 cleared", 8'h80);
        evt_start = 1; tick(); clear_events();
        evt_prog_fail = 1; evt_done = 1; clr_status = 1; tick(); clear_events();
        expect_status("R4 fail beats clear", 8'h90);
        clr_status = 1; tick(); clear_events();
        expect_status("R4 cleared again", 8'h80);
        evt_erase_fail = 1; tick(); clear_events();
        check("R11 lock from efail", err_lock, 1);
        clr_status = 1; tick(); clear_events();
        check("R11 lock off", err_lock, 0);
    endtask

    task automatic t_suspend();
        evt_suspend = 1; tick(); clear_events();
        expect_status("R5 suspend ignored when ready", 8'h80);
        evt_start = 1; tick(); clear_events();
        evt_suspend = 1; tick(); clear_events();
        expect_status("R5 suspended", 8'hC0);
        evt_resume = 1; tick(); clear_events();
        expect_status("R5 resumed", 8'h00);
        evt_resume = 1; tick(); clear_events();
        expect_status("R5 resume ignored", 8'h00);
        evt_done = 1; tick(); clear_events();
        expect_status("R5 done after resume", 8'h80);
    endtask

    task automatic t_sleep();
        evt_start = 1; tick(); clear_events();
        evt_suspend = 1; tick(); clear_events();
        evt_sleep_enter = 1; tick(); clear_events();
        expect_status("R6 sleep ignored when suspended", 8'hC0);
        evt_resume = 1; tick(); clear_events();
        evt_done = 1; tick(); clear_events();
        evt_sleep_enter = 1; tick(); clear_events();
        expect_status("R6 asleep", 8'h84);
        evt_sleep_exit = 1; tick(); clear_events();
        expect_status("R6 awake", 8'h80);
    endtask

    task automatic t_snapshot();
        // Read begins in the same cycle as a start pulse: pre-edge value.
        rd_oe_n = 0; rd_ce_n = 0; evt_start = 1;
        tick(); clear_events();
        check("R8 pre-edge capture", rd_data, 16'h0080);
        evt_done = 1; tick(); clear_events();
        check("R8 frozen across events", rd_data, 16'h0080);
        evt_prog_fail = 1; tick(); clear_events();
        check("R8 still frozen", rd_data, 16'h0080);
        rd_oe_n = 1; tick();
        check("R9 idle after oe release", rd_data, 0);
        rd_oe_n = 0; tick();
        check("R8 fresh capture", rd_data, 16'h0090);
        rd_ce_n = 1; tick();
        check("R9 idle after ce release", rd_data, 0);
        rd_oe_n = 1;
        clr_status = 1; tick(); clear_events();
    endtask

    task automatic t_byte();
        logic [DATA_W-1:0] v;
        word_mode = 0;
        read_status(v);
        check("R10 byte mirror", v, 16'h8080);
        evt_prog_fail = 1; tick(); clear_events();
        read_status(v);
        check("R10 byte mirror fail", v, 16'h9090);
        word_mode = 1;
        read_status(v);
        check("R10 word upper zero", v, 16'h0090);
        clr_status = 1; tick(); clear_events();
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst_n = 1;
        tick();
        t_reset();
        t_busy_done();
        t_fail();
        t_clear();
        t_suspend();
        t_sleep();
        t_snapshot();
        t_byte();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule